// File: doc/BRIEF.md
# Execute-in-Place Serial Flash Fetch Sequencer

This block sits between an instruction or data fetch port and a serial flash wired in four-lane (default) or two-lane I/O mode. A fetch request carries a byte address. The block runs one fast read of a 32-bit word and hands that word back with a single-cycle valid pulse. It drives the chip select, the serial clock and the four IO lines, each IO line with its own output enable. The serial clock comes from a plain divider of the system clock.

After reset the flash may still be stuck in its opcode-free continuous read state, so the block first sends a blind release pattern. Only after that does it accept requests. Each read ends with a mode byte. The block tracks internally whether the flash was told to stay in continuous mode. If so, the next fetch skips the 8-clock opcode and starts with the address. The requester can raise a "last" flag with a fetch. That fetch then sends an exit mode byte, so the flash returns to normal command decoding.

Top module: `xip_fetch_seq`

## Requirements
- R1: After reset, no request is accepted until the block has run one release transaction. With four lanes this is 8 serial clocks; with two lanes it is 16. During the whole release, every IO line is enabled and driven high.
- R2: `req_ready` is high only while chip select is high (deasserted). Chip select stays high for at least 2 system cycles between any two transactions.
- R3: The serial clock rests low whenever chip select is high. Outputs change only after a falling edge, and input lanes are captured at the rising edge.
- R4: When the flash is not in continuous mode, a fetch opens with opcode 0xEB (0xBB with two lanes). The opcode is sent most significant bit first on IO0 over 8 clocks. During the opcode IO1 is released and IO3:IO2 are driven high.
- R5: The address follows most significant bits first. Each clock carries 4 bits on IO3:IO0, with IO3 the most significant, so 24 bits take 6 clocks.
- R6: The mode byte follows the address over 2 clocks. It is 0x20 (bit 5 set, bit 4 clear, all other bits 0) when `req_last` was 0, and 0x00 when `req_last` was 1.
- R7: After the mode byte come 4 dummy clocks and then 8 data clocks. From the first dummy clock until chip select rises, all four IO output enables are low.
- R8: The first data nibble sampled lands in `rsp_data[31:28]` and each later nibble fills the next lower nibble. `rsp_valid` pulses for exactly one cycle, in the cycle where chip select returns high.
- R9: A fetch that follows a 0x20 mode byte omits the opcode and takes 20 serial clocks. A fetch that follows a 0x00 mode byte, or the release, carries the opcode and takes 28 serial clocks.
- R10: Each serial clock half period lasts exactly `SCK_HALF` system cycles (default 2). A transaction of N serial clocks therefore holds chip select low for N*2*SCK_HALF cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | ADDR_W | Byte address of the word to fetch |
| req_last | input | 1 | Send the exit mode byte with this fetch |
| req_ready | output | 1 | Block can take a fetch this cycle |
| rsp_valid | output | 1 | One-cycle pulse, fetched word on rsp_data |
| rsp_data | output | 32 | Fetched word, first received bits at the top |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Serial clock, idle low |
| io_out | output | 4 | Values driven onto IO3..IO0 |
| io_oe | output | 4 | Per-line output enable for IO3..IO0 |
| io_in | input | 4 | Values read from IO3..IO0 |

## Verification
The assertions check the cycle-level rules on every cycle:
- ready only while chip select is high;
- serial clock low while deselected and frozen between divider ticks;
- the minimum deselect gap;
- released lanes during dummy and data clocks;
- no opcode phase while the continuous flag is set;
- a one-cycle response pulse;
- no acceptance before the release.

Only the bench's flash model can show the content and the ordering of the transactions. That covers the opcode bits, address and mode byte seen on the wires, the data word assembled from the lanes, the 20-versus-28 clock lengths that follow each mode byte, and the fresh release after a reset that lands while the flash is in continuous mode.

// File: rtl/xip_pkg.sv
package xip_pkg;

    typedef enum logic [1:0] {
        ST_GAP,
        ST_IDLE,
        ST_XFER
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_REL,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA
    } seq_phase_e;

    localparam logic [7:0] MODE_KEEP = 8'h20;
    localparam logic [7:0] MODE_EXIT = 8'h00;

endpackage

// File: rtl/xip_sck_div.sv
module xip_sck_div #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = en && (cnt_q == CW'(SCK_HALF - 1));
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/xip_rx_word.sv
module xip_rx_word #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic [LANES-1:0] lanes_in,
    output logic [31:0]      word
);
    logic [31:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift) begin
            word_d = {word_q[31-LANES:0], lanes_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/xip_fetch_seq.sv
module xip_fetch_seq
    import xip_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LANES      = 4,
    parameter int SCK_HALF   = 2,
    parameter int GAP_CYC    = 2,
    parameter int DUMMY_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_last,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              flash_cs_n,
    output logic              flash_sck,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);
    localparam logic [7:0] OPCODE    = (LANES == 4) ? 8'hEB : 8'hBB;
    localparam int         REL_CLKS  = 32 / LANES;
    localparam int         ADDR_CLKS = ADDR_W / LANES;
    localparam int         MODE_CLKS = 8 / LANES;
    localparam int         DATA_CLKS = 32 / LANES;
    localparam int         DUMMY_N   = (LANES == 4) ? DUMMY_CLKS : 0;
    localparam int         CNT_W     = 6;
    localparam int         GAP_W     = $clog2(GAP_CYC) + 1;
    localparam logic [3:0] LANE_MASK = (LANES == 4) ? 4'hF : 4'h3;
    localparam logic [3:0] HI_MASK   = ~LANE_MASK;

    typedef struct packed {
        seq_state_e        st;
        seq_phase_e        ph;
        logic [CNT_W-1:0]  cnt;
        logic [GAP_W-1:0]  gap;
        logic              cs_n;
        logic              sck;
        logic              cont;
        logic              rel_pend;
        logic              last;
        logic [ADDR_W-1:0] addr;
        logic              rsp_v;
    } seq_regs_t;

    seq_regs_t q, d;
    logic      tick;
    logic      rx_shift;

    function automatic logic [CNT_W-1:0] phase_len(input seq_phase_e p);
        case (p)
            PH_REL:   phase_len = CNT_W'(REL_CLKS);
            PH_CMD:   phase_len = CNT_W'(8);
            PH_ADDR:  phase_len = CNT_W'(ADDR_CLKS);
            PH_MODE:  phase_len = CNT_W'(MODE_CLKS);
            PH_DUMMY: phase_len = CNT_W'(DUMMY_N);
            default:  phase_len = CNT_W'(DATA_CLKS);
        endcase
    endfunction

    xip_sck_div #(.SCK_HALF(SCK_HALF)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.st == ST_XFER),
        .tick  (tick)
    );

    xip_rx_word #(.LANES(LANES)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (rx_shift),
        .lanes_in (io_in[LANES-1:0]),
        .word     (rsp_data)
    );

    // next-state logic
    always_comb begin
        d        = q;
        d.rsp_v  = 1'b0;
        rx_shift = 1'b0;
        case (q.st)
            ST_GAP: begin
                if (q.gap == GAP_W'(GAP_CYC - 1)) begin
                    if (q.rel_pend) begin
                        d.st       = ST_XFER;
                        d.ph       = PH_REL;
                        d.cnt      = '0;
                        d.cs_n     = 1'b0;
                        d.rel_pend = 1'b0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_XFER;
                    d.cs_n = 1'b0;
                    d.cnt  = '0;
                    d.addr = req_addr;
                    d.last = req_last;
                    d.ph   = q.cont ? PH_ADDR : PH_CMD;
                end
            end
            default: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck    = 1'b1;
                        rx_shift = (q.ph == PH_DATA);
                    end else begin
                        d.sck = 1'b0;
                        if (q.cnt == phase_len(q.ph) - 1'b1) begin
                            d.cnt = '0;
                            case (q.ph)
                                PH_REL: begin
                                    d.cont = 1'b0;
                                    d.st   = ST_GAP;
                                    d.gap  = '0;
                                    d.cs_n = 1'b1;
                                end
                                PH_CMD:  d.ph = PH_ADDR;
                                PH_ADDR: d.ph = PH_MODE;
                                PH_MODE: begin
                                    d.cont = !q.last;
                                    d.ph   = (DUMMY_N > 0) ? PH_DUMMY : PH_DATA;
                                end
                                PH_DUMMY: d.ph = PH_DATA;
                                default: begin
                                    d.st    = ST_GAP;
                                    d.gap   = '0;
                                    d.cs_n  = 1'b1;
                                    d.rsp_v = 1'b1;
                                end
                            endcase
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_GAP;
            q.ph       <= PH_REL;
            q.cnt      <= '0;
            q.gap      <= '0;
            q.cs_n     <= 1'b1;
            q.sck      <= 1'b0;
            q.cont     <= 1'b0;
            q.rel_pend <= 1'b1;
            q.last     <= 1'b0;
            q.addr     <= '0;
            q.rsp_v    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // line drive, derived from registered phase and count
    always_comb begin
        logic [7:0]       mbyte;
        logic [LANES-1:0] a_lanes;
        logic [LANES-1:0] m_lanes;
        mbyte   = q.last ? MODE_EXIT : MODE_KEEP;
        a_lanes = LANES'((q.addr << (LANES * q.cnt)) >> (ADDR_W - LANES));
        m_lanes = LANES'((mbyte << (LANES * q.cnt)) >> (8 - LANES));
        io_out  = 4'h0;
        io_oe   = 4'h0;
        if (!q.cs_n) begin
            case (q.ph)
                PH_REL: begin
                    io_out = 4'hF;
                    io_oe  = 4'hF;
                end
                PH_CMD: begin
                    io_out = {3'b110, 1'((OPCODE << q.cnt) >> 7)};
                    io_oe  = 4'b1101;
                end
                PH_ADDR: begin
                    io_out = HI_MASK | 4'(a_lanes);
                    io_oe  = 4'hF;
                end
                PH_MODE: begin
                    io_out = HI_MASK | 4'(m_lanes);
                    io_oe  = 4'hF;
                end
                default: begin
                    io_out = HI_MASK;
                    io_oe  = HI_MASK;
                end
            endcase
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign rsp_valid  = q.rsp_v;
    assign flash_cs_n = q.cs_n;
    assign flash_sck  = q.sck;

    // ---------------- assertions ----------------
    localparam int HR_W = $clog2(GAP_CYC + 1) + 1;
    logic [HR_W-1:0] hi_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (!flash_cs_n) begin
            hi_run_q <= '0;
        end else if (hi_run_q < HR_W'(GAP_CYC)) begin
            hi_run_q <= hi_run_q + 1'b1;
        end
    end

    a_r2_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> flash_cs_n);

    a_r2_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_cs_n) |-> (hi_run_q >= HR_W'(GAP_CYC)));

    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> !flash_sck);

    a_r10_sck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(flash_sck));

    a_r7_lanes_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_cs_n && (q.ph == PH_DUMMY || q.ph == PH_DATA)) |-> ((io_oe & LANE_MASK) == 4'h0));

    a_r9_no_opcode_in_cont: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_cs_n && q.ph == PH_CMD) |-> !q.cont);

    a_r8_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r1_release_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !q.rel_pend);

endmodule

// File: tb/xip_fetch_seq_tb_top.sv
module xip_fetch_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_last;
    logic [23:0] req_addr;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic        flash_cs_n, flash_sck;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = 4'h0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xip_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_last(req_last), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .flash_cs_n(flash_cs_n), .flash_sck(flash_sck),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [31:0] word_of(input logic [23:0] a);
        return {a[7:0], a[15:8] ^ 8'h5A, a[23:16], ~a[7:0]};
    endfunction

    // flash model: starts stuck in continuous mode
    logic        mdl_cont = 1'b1;
    logic        prev_cs = 1'b1, prev_sck = 1'b0;
    int          rise_cnt = 0, low_cyc = 0, hi_cyc = 0;
    int          min_gap = 1000, bad_ready = 0, tr_count = 0;
    int          tr_len = 0, tr_low = 0;
    logic        all_f, opc_oe_ok, rel_oe_ok;
    logic        tr_allf, tr_opc_oe_ok, tr_rel_oe_ok;
    logic [7:0]  opc, mode, tr_opc, tr_mode;
    logic [23:0] addr, tr_addr;

    always @(negedge clk) begin
        int off;
        int di;
        logic [3:0] s;
        off = mdl_cont ? 0 : 8;
        if (!flash_cs_n && req_ready) bad_ready++;
        if (!flash_cs_n && prev_cs) begin
            if (tr_count > 0 && hi_cyc < min_gap) min_gap = hi_cyc;
            rise_cnt = 0; low_cyc = 0; all_f = 1'b1; opc_oe_ok = 1'b1; rel_oe_ok = 1'b1;
            opc = 8'h0; mode = 8'h0; addr = 24'h0;
        end
        if (!flash_cs_n) low_cyc++;
        else hi_cyc++;
        if (!flash_cs_n && flash_sck && !prev_sck) begin
            s = io_out & io_oe;
            if (!(io_oe == 4'hF && io_out == 4'hF)) all_f = 1'b0;
            if (!mdl_cont && rise_cnt < 8) begin
                opc = {opc[6:0], s[0]};
                if (io_oe != 4'b1101 || io_out[3:2] != 2'b11) opc_oe_ok = 1'b0;
            end else if (rise_cnt >= off && rise_cnt < off + 6) begin
                addr = {addr[19:0], s};
            end else if (rise_cnt >= off + 6 && rise_cnt < off + 8) begin
                mode = {mode[3:0], s};
            end else if (rise_cnt >= off + 8 && io_oe != 4'h0) begin
                rel_oe_ok = 1'b0;
            end
            rise_cnt++;
        end
        if (flash_cs_n && !prev_cs) begin
            tr_len = rise_cnt; tr_low = low_cyc; tr_count++;
            tr_allf = all_f; tr_opc = opc; tr_addr = addr; tr_mode = mode;
            tr_opc_oe_ok = opc_oe_ok; tr_rel_oe_ok = rel_oe_ok;
            if (rise_cnt == 8 && all_f) mdl_cont = 1'b0;
            else mdl_cont = (mode[5:4] == 2'b10);
            hi_cyc = 0;
        end
        prev_cs = flash_cs_n;
        prev_sck = flash_sck;
        off = mdl_cont ? 0 : 8;
        di = rise_cnt - (off + 12);
        if (!flash_cs_n && di >= 0 && di < 8) io_in = 4'(word_of(addr) >> (28 - 4 * di));
        else io_in = 4'h0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [23:0] a, input logic l, output logic [31:0] dat);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_last = l;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        dat = rsp_data;
        @(negedge clk);
        chk("R8 valid is one cycle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic check_fetch(input logic [23:0] a, input logic l, input logic with_opc,
                               input logic [31:0] dat);
        int n;
        n = with_opc ? 28 : 20;
        chk("R8 data word", dat, word_of(a));
        chk("R9 clock count", 32'(tr_len), 32'(n));
        chk("R10 cs low cycles", 32'(tr_low), 32'(n * 2 * HALF));
        chk("R5 address", 32'(tr_addr), 32'(a));
        chk("R6 mode byte", 32'(tr_mode), l ? 32'h00 : 32'h20);
        chk("R7 lanes released", 32'(tr_rel_oe_ok), 32'd1);
        if (with_opc) begin
            chk("R4 opcode", 32'(tr_opc), 32'hEB);
            chk("R4 opcode line enables", 32'(tr_opc_oe_ok), 32'd1);
        end
    endtask

    localparam logic [24:0] VEC [6] = '{
        {24'h000100, 1'b0},
        {24'h123456, 1'b0},
        {24'hFFFFFC, 1'b1},
        {24'h000000, 1'b0},
        {24'hA5A5A4, 1'b1},
        {24'h7FFFF0, 1'b1}
    };

    initial begin
        logic [31:0] dat;
        logic        prev_last;
        int          base;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_last = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 cs high in reset", 32'(flash_cs_n), 32'd1);
        chk("R3 sck low in reset", 32'(flash_sck), 32'd0);
        chk("R2 not ready in reset", 32'(req_ready), 32'd0);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk("R1 one transaction before ready", 32'(tr_count), 32'd1);
        chk("R1 release length", 32'(tr_len), 32'd8);
        chk("R1 release lines high", 32'(tr_allf), 32'd1);
        chk("R10 release cs low cycles", 32'(tr_low), 32'(8 * 2 * HALF));

        prev_last = 1'b1;
        for (int i = 0; i < 6; i++) begin
            do_fetch(VEC[i][24:1], VEC[i][0], dat);
            check_fetch(VEC[i][24:1], VEC[i][0], prev_last, dat);
            prev_last = VEC[i][0];
        end

        // reset while flash sits in continuous mode
        do_fetch(24'h000040, 1'b0, dat);
        check_fetch(24'h000040, 1'b0, 1'b1, dat);
        @(negedge clk);
        base = tr_count;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 not ready in second reset", 32'(req_ready), 32'd0);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk("R1 release after reset", 32'(tr_count - base), 32'd1);
        chk("R1 release length again", 32'(tr_len), 32'd8);
        chk("R1 release lines high again", 32'(tr_allf), 32'd1);
        do_fetch(24'h000080, 1'b1, dat);
        check_fetch(24'h000080, 1'b1, 1'b1, dat);

        chk("R2 minimum deselect gap", 32'(min_gap >= 2), 32'd1);
        chk("R2 no ready while selected", 32'(bad_ready), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule